// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Cache Lookup

This block is the lookup stage of a set-associative first-level data cache. The set is chosen from untranslated page-offset bits, so set selection starts in the same cycle the core issues the request, while address translation is still running. One cycle later the translated physical page number arrives with a translation-valid flag. That page number is compared against the stored tags of the set that was already read.

The line-offset and set-index fields together fill the 12-bit page offset exactly. The physical page number can therefore serve as the whole tag, and the virtual and physical index can never disagree. The stage is pipelined: a new request may be issued in the same cycle as the page number of the previous request.

A fill port writes a complete line, its tag and its valid bit into a chosen set and way. It exists to load contents for testing. Refill policy, write handling and coherence belong to other blocks.

Top module: `vipt_lookup`

## Requirements
- R1: While reset is asserted, and afterwards until the first fill, every valid bit is clear. `hit_o` is 0 during reset and in the first cycle after it, and any lookup made before a fill misses.
- R2: The set is taken from request-offset bits [11:6] and the 64-bit word from bits [5:3]. Bits [2:0] have no effect on any output.
- R3: A request is captured at clock edge E0 and its page number and translation flag at edge E1. The registered result is visible from E1 until the next edge, so back-to-back requests produce back-to-back results.
- R4: On a hit, `way_o` gives the index of the matching way, and `data_o` gives word k of that line, where word k occupies line bits [64k+63:64k].
- R5: If `xlat_valid_i` is low in the cycle the page number is presented, the lookup is cancelled: `hit_o`, `way_o` and `data_o` are all 0.
- R6: When no valid line in the set has a tag equal to the page number, `hit_o` is 0. Whenever `hit_o` is 0, `way_o` and `data_o` are also 0.
- R7: A fill writes the line, the 40-bit tag and the given valid bit into the given set and way. A fill with the valid bit low removes the line from any later match.
- R8: A lookup whose request edge is also the edge of a fill to the same set sees the set's contents from before that fill.
- R9: If more than one valid way of the set carries the matching tag, the lowest-numbered of those ways is reported.
- R10: With `req_valid_i` low at the request edge, the result is a miss whatever page number follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Lookup request in the first cycle |
| req_offset_i | input | 12 | Page-offset part of the virtual address |
| xlat_valid_i | input | 1 | Translation succeeded (second cycle) |
| xlat_ppn_i | input | 40 | Physical page number (second cycle) |
| fill_en_i | input | 1 | Write one line |
| fill_set_i | input | 6 | Set to write |
| fill_way_i | input | 3 | Way to write |
| fill_tag_i | input | 40 | Tag to store |
| fill_valid_i | input | 1 | Valid bit to store |
| fill_line_i | input | 512 | Line data, word k at bits [64k+63:64k] |
| hit_o | output | 1 | Lookup hit |
| way_o | output | 3 | Hitting way, 0 otherwise |
| data_o | output | 64 | Selected word, 0 otherwise |

## Verification
Every result is due exactly two rising edges after its request: the request edge and then the page-number edge. The bench drives all inputs on falling edges and samples on the falling edge that follows the page-number edge. Fills take effect at the edge on which they are driven. Each check is therefore placed one full cycle after the relevant edge, and the R8 case places the fill and the request on the same edge on purpose. A pipelined pair of requests checks that the second result follows the first by one cycle.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    parameter int SETS       = 64;
    parameter int WAYS       = 8;
    parameter int LINE_BYTES = 64;
    parameter int WORD_BYTES = 8;
    parameter int TAG_W      = 40;

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int SET_W      = $clog2(SETS);
    localparam int PAGE_OFF_W = OFF_W + SET_W;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int WB_W       = $clog2(WORD_BYTES);
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;

    // Pipeline state: first-cycle set snapshot, second-cycle result
    typedef struct packed {
        logic                 req;
        tag_t  [WAYS-1:0]     tags;
        logic  [WAYS-1:0]     vlds;
        word_t [WAYS-1:0]     words;
        logic                 hit;
        way_t                 way;
        word_t                data;
    } look_state_t;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  set_t              rd_set_i,
    output tag_t [WAYS-1:0]   rd_tags_o,
    output logic [WAYS-1:0]   rd_vlds_o,
    input  logic              wr_en_i,
    input  set_t              wr_set_i,
    input  way_t              wr_way_i,
    input  tag_t              wr_tag_i,
    input  logic              wr_vld_i
);
    tag_t tag_q [SETS][WAYS];
    logic vld_q [SETS][WAYS];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    vld_q[s][w] <= 1'b0;
        end else if (wr_en_i) begin
            vld_q[wr_set_i][wr_way_i] <= wr_vld_i;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags_o[w] = tag_q[rd_set_i][w];
        assign rd_vlds_o[w] = vld_q[rd_set_i][w];
    end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
    import vipt_pkg::*;
(
    input  logic              clk_i,
    input  set_t              rd_set_i,
    input  wsel_t             rd_wsel_i,
    output word_t [WAYS-1:0]  rd_words_o,
    input  logic              wr_en_i,
    input  set_t              wr_set_i,
    input  way_t              wr_way_i,
    input  line_t             wr_line_i
);
    line_t line_q [SETS][WAYS];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) line_q[wr_set_i][wr_way_i] <= wr_line_i;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_words_o[w] = line_q[rd_set_i][w][rd_wsel_i*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match
    import vipt_pkg::*;
(
    input  logic              en_i,
    input  tag_t              ppn_i,
    input  tag_t [WAYS-1:0]   tags_i,
    input  logic [WAYS-1:0]   vlds_i,
    output logic              hit_o,
    output way_t              way_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = en_i && vlds_i[w] && (tags_i[w] == ppn_i);
    end

    // Scan from the top so the lowest matching way wins
    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = way_t'(w);
        end
    end

    assign hit_o = |match;
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_valid_i,
    input  logic [PAGE_OFF_W-1:0] req_offset_i,
    input  logic                  xlat_valid_i,
    input  logic [TAG_W-1:0]      xlat_ppn_i,
    input  logic                  fill_en_i,
    input  logic [SET_W-1:0]      fill_set_i,
    input  logic [WAY_W-1:0]      fill_way_i,
    input  logic [TAG_W-1:0]      fill_tag_i,
    input  logic                  fill_valid_i,
    input  logic [LINE_W-1:0]     fill_line_i,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      way_o,
    output logic [WORD_W-1:0]     data_o
);
    look_state_t s_d, s_q;

    set_t             rd_set;
    wsel_t            rd_wsel;
    tag_t  [WAYS-1:0] set_tags;
    logic  [WAYS-1:0] set_vlds;
    word_t [WAYS-1:0] set_words;
    logic             m_hit;
    way_t             m_way;
    logic             unused_byte_sel;

    assign rd_set          = req_offset_i[PAGE_OFF_W-1:OFF_W];
    assign rd_wsel         = req_offset_i[OFF_W-1:WB_W];
    assign unused_byte_sel = ^req_offset_i[WB_W-1:0];

    vipt_tag_store u_tags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_set_i  (rd_set),
        .rd_tags_o (set_tags),
        .rd_vlds_o (set_vlds),
        .wr_en_i   (fill_en_i),
        .wr_set_i  (fill_set_i),
        .wr_way_i  (fill_way_i),
        .wr_tag_i  (fill_tag_i),
        .wr_vld_i  (fill_valid_i)
    );

    vipt_data_store u_data (
        .clk_i      (clk_i),
        .rd_set_i   (rd_set),
        .rd_wsel_i  (rd_wsel),
        .rd_words_o (set_words),
        .wr_en_i    (fill_en_i),
        .wr_set_i   (fill_set_i),
        .wr_way_i   (fill_way_i),
        .wr_line_i  (fill_line_i)
    );

    vipt_way_match u_match (
        .en_i   (s_q.req && xlat_valid_i),
        .ppn_i  (xlat_ppn_i),
        .tags_i (s_q.tags),
        .vlds_i (s_q.vlds),
        .hit_o  (m_hit),
        .way_o  (m_way)
    );

    always_comb begin
        s_d       = s_q;
        // First cycle: snapshot of the indexed set
        s_d.req   = req_valid_i;
        s_d.tags  = set_tags;
        s_d.vlds  = set_vlds;
        s_d.words = set_words;
        // Second cycle: compare against the translated page number
        s_d.hit   = m_hit;
        s_d.way   = m_hit ? m_way : '0;
        s_d.data  = m_hit ? s_q.words[m_way] : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign hit_o  = s_q.hit;
    assign way_o  = s_q.way;
    assign data_o = s_q.data;
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk
    import vipt_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              xlat_valid_i,
    input logic              hit_o,
    input logic [WAY_W-1:0]  way_o,
    input logic [WORD_W-1:0] data_o
);
    // R1: the first cycle out of reset reports no hit
    a_r1_clear_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> !hit_o);

    // R5: a failed translation cancels the lookup
    a_r5_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(xlat_valid_i) |-> !hit_o);

    // R10: no request, no hit two edges later
    a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(req_valid_i, 2) |-> !hit_o);

    // R6: a miss drives way and data to zero
    a_r6_zero_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (way_o == '0 && data_o == '0));

    // R3: a hit needs a request two edges back and a good translation one edge back
    a_r3_hit_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> ($past(req_valid_i, 2) && $past(xlat_valid_i)));
endmodule

bind vipt_lookup vipt_lookup_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .xlat_valid_i (xlat_valid_i),
    .hit_o        (hit_o),
    .way_o        (way_o),
    .data_o       (data_o)
);

// File: tb/vipt_lookup_test.sv
module vipt_lookup_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [11:0]  req_offset = '0;
    logic         xlat_valid = 1'b0;
    logic [39:0]  xlat_ppn = '0;
    logic         fill_en = 1'b0;
    logic [5:0]   fill_set = '0;
    logic [2:0]   fill_way = '0;
    logic [39:0]  fill_tag = '0;
    logic         fill_valid = 1'b0;
    logic [511:0] fill_line = '0;
    logic         hit;
    logic [2:0]   way;
    logic [63:0]  data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vipt_lookup uut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_offset_i(req_offset),
        .xlat_valid_i(xlat_valid), .xlat_ppn_i(xlat_ppn),
        .fill_en_i(fill_en), .fill_set_i(fill_set), .fill_way_i(fill_way),
        .fill_tag_i(fill_tag), .fill_valid_i(fill_valid), .fill_line_i(fill_line),
        .hit_o(hit), .way_o(way), .data_o(data)
    );

    localparam logic [39:0] TA = 40'h12_3456_789A;
    localparam logic [39:0] TB = 40'hFE_DCBA_9876;
    localparam logic [39:0] TC = 40'h00_0000_002D;
    localparam logic [39:0] TD = 40'h80_0000_0001;
    localparam logic [39:0] TE = 40'h55_AA55_AA55;
    localparam logic [39:0] TF = 40'h3C_3C3C_3C3C;
    localparam logic [39:0] TG = 40'h0F_0F0F_0F0F;

    function automatic logic [63:0] pat(logic [5:0] s, logic [2:0] w, logic [2:0] k, logic [7:0] g);
        return {g, 2'b00, s, 5'b0, w, 5'b0, k, 32'h5EED_F00D};
    endfunction

    function automatic logic [511:0] mkline(logic [5:0] s, logic [2:0] w, logic [7:0] g);
        logic [511:0] l;
        for (int k = 0; k < 8; k++) l[k*64 +: 64] = pat(s, w, 3'(k), g);
        return l;
    endfunction

    typedef struct packed {
        logic        req;
        logic [11:0] off;
        logic [39:0] ppn;
        logic        xv;
        logic        hit;
        logic [2:0]  way;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, {6'h0F, 3'd2, 3'd5}, TA, 1'b1, 1'b1, 3'd0},  // R2 R4 byte bits ignored
        '{1'b1, {6'h0F, 3'd7, 3'd0}, TB, 1'b1, 1'b1, 3'd3},  // R4 top word
        '{1'b1, {6'h2D, 3'd0, 3'd0}, TC, 1'b1, 1'b1, 3'd7},  // R4 last way
        '{1'b1, {6'h00, 3'd4, 3'd3}, TA, 1'b1, 1'b1, 3'd5},  // R2 same tag other set
        '{1'b1, {6'h3F, 3'd6, 3'd1}, TD, 1'b1, 1'b1, 3'd1},  // R2 top set
        '{1'b1, {6'h21, 3'd1, 3'd0}, TE, 1'b1, 1'b1, 3'd4},  // R9 duplicate tags
        '{1'b1, {6'h0F, 3'd2, 3'd0}, TC, 1'b1, 1'b0, 3'd0},  // R6 tag mismatch
        '{1'b1, {6'h0F, 3'd2, 3'd0}, TA, 1'b0, 1'b0, 3'd0},  // R5 cancelled
        '{1'b0, {6'h2D, 3'd3, 3'd0}, TC, 1'b1, 1'b0, 3'd0},  // R10 no request
        '{1'b1, {6'h10, 3'd0, 3'd0}, TA, 1'b1, 1'b0, 3'd0}   // R6 empty set
    };

    task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_fill(logic [5:0] s, logic [2:0] w, logic [39:0] t, logic v, logic [7:0] g);
        @(negedge clk);
        fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t;
        fill_valid = v; fill_line = mkline(s, w, g);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Request on one edge, page number on the next, sample one cycle later
    task automatic lookup(logic rq, logic [11:0] off, logic [39:0] ppn, logic xv);
        @(negedge clk);
        req_valid = rq; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0; xlat_ppn = ppn; xlat_valid = xv;
        @(negedge clk);
        xlat_valid = 1'b0;
    endtask

    task automatic expect_res(string rq, logic h, logic [2:0] w, logic [63:0] d);
        check(rq, 64'(hit), 64'(h));
        check(rq, 64'(way), 64'(w));
        check(rq, data, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 64'(hit), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(hit), 64'd0);
        lookup(1'b1, {6'h0F, 3'd0, 3'd0}, 40'h0, 1'b1);
        expect_res("R1", 1'b0, 3'd0, 64'd0);

        do_fill(6'h0F, 3'd0, TA, 1'b1, 8'h01);
        do_fill(6'h0F, 3'd3, TB, 1'b1, 8'h01);
        do_fill(6'h2D, 3'd7, TC, 1'b1, 8'h01);
        do_fill(6'h00, 3'd5, TA, 1'b1, 8'h01);
        do_fill(6'h3F, 3'd1, TD, 1'b1, 8'h01);
        do_fill(6'h21, 3'd6, TE, 1'b1, 8'h01);
        do_fill(6'h21, 3'd4, TE, 1'b1, 8'h01);

        for (int i = 0; i < 10; i++) begin
            vec_t v = VECS[i];
            logic [63:0] exp_d = v.hit ? pat(v.off[11:6], v.way, v.off[5:3], 8'h01) : 64'd0;
            lookup(v.req, v.off, v.ppn, v.xv);
            expect_res($sformatf("R3 vec%0d", i), v.hit, v.way, exp_d);
        end

        // R7: invalidate, then overwrite with a new tag
        do_fill(6'h2D, 3'd7, TC, 1'b0, 8'h02);
        lookup(1'b1, {6'h2D, 3'd0, 3'd0}, TC, 1'b1);
        expect_res("R7 invalidated", 1'b0, 3'd0, 64'd0);
        do_fill(6'h0F, 3'd0, TF, 1'b1, 8'h03);
        lookup(1'b1, {6'h0F, 3'd1, 3'd0}, TA, 1'b1);
        expect_res("R7 old tag", 1'b0, 3'd0, 64'd0);
        lookup(1'b1, {6'h0F, 3'd1, 3'd0}, TF, 1'b1);
        expect_res("R7 new tag", 1'b1, 3'd0, pat(6'h0F, 3'd0, 3'd1, 8'h03));

        // R8: fill and request share an edge; lookup sees the old line
        @(negedge clk);
        req_valid = 1'b1; req_offset = {6'h0F, 3'd6, 3'd0};
        fill_en = 1'b1; fill_set = 6'h0F; fill_way = 3'd0; fill_tag = TG;
        fill_valid = 1'b1; fill_line = mkline(6'h0F, 3'd0, 8'h04);
        @(negedge clk);
        req_valid = 1'b0; fill_en = 1'b0; xlat_ppn = TF; xlat_valid = 1'b1;
        @(negedge clk);
        xlat_valid = 1'b0;
        expect_res("R8 old contents", 1'b1, 3'd0, pat(6'h0F, 3'd0, 3'd6, 8'h03));
        lookup(1'b1, {6'h0F, 3'd6, 3'd0}, TG, 1'b1);
        expect_res("R8 new contents", 1'b1, 3'd0, pat(6'h0F, 3'd0, 3'd6, 8'h04));

        // R3: back-to-back requests, results one cycle apart
        @(negedge clk);
        req_valid = 1'b1; req_offset = {6'h0F, 3'd5, 3'd0};
        @(negedge clk);
        req_offset = {6'h3F, 3'd2, 3'd0}; xlat_ppn = TB; xlat_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; xlat_ppn = TD;
        expect_res("R3 first of pair", 1'b1, 3'd3, pat(6'h0F, 3'd3, 3'd5, 8'h01));
        @(negedge clk);
        xlat_valid = 1'b0;
        expect_res("R3 second of pair", 1'b1, 3'd1, pat(6'h3F, 3'd1, 3'd2, 8'h01));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule